// File: doc/BRIEF.md
# Peripheral Interrupt and Soft-Reset Unit

This block sits beside a serial peripheral core and gathers the core's event signals into one interrupt line for the host. Seven event inputs come from the core: mode fault, slave mode fault, transmit empty, transmit underrun, receive full, receive overrun and transmit half empty. A rising edge on an event input sets a sticky bit in a status register. A per-source enable register and a single global enable bit mask the status bits before they drive the interrupt output. The host acknowledges events by writing ones into the status register. A write of the value it has just read is the normal way to do this.

The block also provides a software reset. A write of one key value to the reset register clears this block's registers and sends a reset pulse of fixed length to the core. Any other value written there is discarded. All registers are reached over a simple 32-bit register bus. Writes are strobed for one cycle, and reads are combinational from the address.

Top module: `periph_irq_ctrl`

## Requirements
- R1: While and after the synchronous active-low reset, the global enable, enable and status registers read 0, and `irq_o` and `core_rst_o` are 0.
- R2: A rising edge on `evt_i[k]` sets status bit k. The bit map is: 0 mode fault, 1 slave mode fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun, 6 transmit half empty. The bit is readable in the cycle after the edge where the input was first sampled high. An input held high sets its bit only once.
- R3: A status bit stays set until a write to offset 0x20 carries a 1 in that bit position. Zero bits in the write leave status unchanged, so writing back the value read clears exactly the bits that were set.
- R4: When a clearing write and a new rising edge hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x28 holds bits 6:0 as written. Bits 31:7 read 0.
- R6: The global enable register at offset 0x1C stores only bit 31. All other bits read 0.
- R7: `irq_o` is 1 exactly when the global enable is 1 and at least one status bit is set whose enable bit is also set.
- R8: A write of 0x0000000A to offset 0x40 clears the global enable, enable and status registers at that clock edge, even if a new event edge arrives in the same cycle. It also drives `core_rst_o` high for RST_CYCLES (default 4) cycles, starting in the next cycle.
- R9: A write of any other value to offset 0x40 has no effect. No reset pulse appears, and all registers keep their values.
- R10: Reads of offset 0x40 and of unmapped offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | One-cycle write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_i | input | NUM_EVT | Event inputs from the core |
| irq_o | output | 1 | Masked interrupt request |
| core_rst_o | output | 1 | Reset pulse to the core |

## Verification
The hardest cases to reach from the ports are the ones where two things land on the same clock edge. One is a clearing write colliding with a fresh event edge on the same bit. The other is a key write to the reset register colliding with an event edge. The bench reaches both by driving the write strobe and the event vector together on one falling edge, so that the next rising edge sees both. It then reads the status register back. Every combination of enable mask is also swept against a status pattern that varies arithmetically with the mask. Each pass clears the status by writing back the value read.

// File: rtl/pirq_pkg.sv
// Shared constants and types for the peripheral interrupt and soft-reset unit.
// Assumes a byte-addressed register map with 32-bit registers.
package pirq_pkg;
    localparam logic [7:0]  OFS_GIE  = 8'h1C;
    localparam logic [7:0]  OFS_STS  = 8'h20;
    localparam logic [7:0]  OFS_IER  = 8'h28;
    localparam logic [7:0]  OFS_SRST = 8'h40;
    localparam logic [31:0] SRST_KEY = 32'h0000_000A;
    localparam int unsigned GIE_BIT  = 31;

    // Decoded write strobes, one per register.
    typedef struct packed {
        logic gie;
        logic sts;
        logic ier;
        logic srst;
    } wr_sel_t;
endpackage

// File: rtl/pirq_edge_det.sv
// Rising-edge detector, one flop per event line.
// Assumes inputs are synchronous to clk. Its history is not cleared by soft reset,
// so a level still held high does not re-fire afterwards.
module pirq_edge_det #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] lvl_q;

    for (genvar k = 0; k < W; k++) begin : g_bit
        // Remember the previous level of line k.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[k] <= 1'b0;
            else        lvl_q[k] <= lvl_i[k];
        end
        assign rise_o[k] = lvl_i[k] & ~lvl_q[k];
    end
endmodule

// File: rtl/pirq_status.sv
// Sticky status bits with write-one-to-clear.
// Set has priority over clear; soft clear has priority over both.
module pirq_status #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr_i,
    input  logic [W-1:0] rise_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] sts_o
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        // Hold bit k until it is acknowledged, re-arm on a new edge.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr_i)
                sts_o[k] <= 1'b0;
            else if (rise_i[k])
                sts_o[k] <= 1'b1;
            else if (clr_we_i && clr_mask_i[k])
                sts_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/pirq_srst_gen.sv
// Reset pulse stretcher: after a fire request, holds pulse_o high for LEN cycles.
// A new request during a pulse restarts the count.
module pirq_srst_gen #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    localparam int unsigned CNT_W = $clog2(LEN + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count down the remaining pulse cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (fire_i)
            cnt_q <= CNT_W'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/periph_irq_ctrl.sv
// Interrupt aggregation and software reset for a serial peripheral core.
// Decodes a 32-bit register bus, latches event edges, masks them into irq_o,
// and issues a reset pulse on the key write. Reads are combinational.
module periph_irq_ctrl #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_EVT    = 7,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o,
    output logic               core_rst_o
);
    import pirq_pkg::*;

    wr_sel_t            sel;
    logic               key_hit;
    logic               gie_q;
    logic [NUM_EVT-1:0] ier_q;
    logic [NUM_EVT-1:0] sts_q;
    logic [NUM_EVT-1:0] rise;

    // Decode the write strobe per register.
    always_comb begin
        sel.gie  = reg_wr_en && (reg_addr == ADDR_W'(OFS_GIE));
        sel.sts  = reg_wr_en && (reg_addr == ADDR_W'(OFS_STS));
        sel.ier  = reg_wr_en && (reg_addr == ADDR_W'(OFS_IER));
        sel.srst = reg_wr_en && (reg_addr == ADDR_W'(OFS_SRST));
    end

    assign key_hit = sel.srst && (reg_wdata == SRST_KEY);

    // Global and per-source enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n || key_hit) begin
            gie_q <= 1'b0;
            ier_q <= '0;
        end else begin
            if (sel.gie) gie_q <= reg_wdata[GIE_BIT];
            if (sel.ier) ier_q <= reg_wdata[NUM_EVT-1:0];
        end
    end

    pirq_edge_det #(.W(NUM_EVT)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (evt_i),
        .rise_o (rise)
    );

    pirq_status #(.W(NUM_EVT)) u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr_i (key_hit),
        .rise_i     (rise),
        .clr_we_i   (sel.sts),
        .clr_mask_i (reg_wdata[NUM_EVT-1:0]),
        .sts_o      (sts_q)
    );

    pirq_srst_gen #(.LEN(RST_CYCLES)) u_srst (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (key_hit),
        .pulse_o (core_rst_o)
    );

    // Read multiplexer; reset register and holes read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFS_GIE): reg_rdata[GIE_BIT] = gie_q;
            ADDR_W'(OFS_STS): reg_rdata = 32'(sts_q);
            ADDR_W'(OFS_IER): reg_rdata = 32'(ier_q);
            default:          reg_rdata = '0;
        endcase
    end

    assign irq_o = gie_q & (|(sts_q & ier_q));
endmodule

// File: rtl/pirq_chk.sv
// Property checker for periph_irq_ctrl, attached by bind.
// Observes bus, events, outputs and the register state.
module pirq_chk #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_EVT    = 7,
    parameter int unsigned RST_CYCLES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [NUM_EVT-1:0] evt_i,
    input logic               irq_o,
    input logic               core_rst_o,
    input logic               gie_q,
    input logic [NUM_EVT-1:0] ier_q,
    input logic [NUM_EVT-1:0] sts_q
);
    import pirq_pkg::*;

    localparam int unsigned HC_W = $clog2(RST_CYCLES + 2);

    logic               wr_srst, wr_key, wr_sts;
    logic [NUM_EVT-1:0] evt_prev;
    logic [HC_W-1:0]    hi_cnt;

    assign wr_srst = reg_wr_en && (reg_addr == ADDR_W'(OFS_SRST));
    assign wr_key  = wr_srst && (reg_wdata == SRST_KEY);
    assign wr_sts  = reg_wr_en && (reg_addr == ADDR_W'(OFS_STS));

    // Track event history and the length of the current reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_prev <= '0;
            hi_cnt   <= '0;
        end else begin
            evt_prev <= evt_i;
            if (!core_rst_o)                    hi_cnt <= '0;
            else if (hi_cnt != HC_W'(RST_CYCLES + 1)) hi_cnt <= hi_cnt + HC_W'(1);
        end
    end

    AST_RST_IDLE: assert property (@(posedge clk) !rst_n |=> (!core_rst_o && !irq_o && sts_q == '0)); // R1
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) !gie_q |-> !irq_o); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) ((sts_q & ier_q) == '0) |-> !irq_o); // R7
    AST_KEY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_key |=> core_rst_o); // R8
    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) wr_key |=> (sts_q == '0 && ier_q == '0 && !gie_q)); // R8
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n) hi_cnt <= HC_W'(RST_CYCLES)); // R8
    AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n) (wr_srst && !wr_key && !core_rst_o) |=> !core_rst_o); // R9

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n) (evt_i[k] && !evt_prev[k] && !wr_key) |=> sts_q[k]); // R4
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (sts_q[k] && !wr_key && !(wr_sts && reg_wdata[k])) |=> sts_q[k]); // R3
    end
endmodule

bind periph_irq_ctrl pirq_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_EVT    (NUM_EVT),
    .RST_CYCLES (RST_CYCLES)
) u_pirq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .evt_i      (evt_i),
    .irq_o      (irq_o),
    .core_rst_o (core_rst_o),
    .gie_q      (gie_q),
    .ier_q      (ier_q),
    .sts_q      (sts_q)
);

// File: tb/test_periph_irq_ctrl.sv
// Self-checking bench: register access, event latching, masking sweep, soft reset.
module test_periph_irq_ctrl;
    localparam int unsigned RST_LEN = 4;
    localparam logic [7:0] A_GIE = 8'h1C, A_STS = 8'h20, A_IER = 8'h28, A_SRST = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  evt = '0;
    logic        irq, crst;
    int          tests = 0, fails = 0;
    bit          done = 1'b0;
    logic [31:0] v;

    always #5 clk = ~clk;

    periph_irq_ctrl #(.ADDR_W(8), .NUM_EVT(7), .RST_CYCLES(RST_LEN)) i_periph_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .evt_i(evt), .irq_o(irq), .core_rst_o(crst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_evt(input logic [6:0] p);
        @(negedge clk);
        evt = p;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 0);
        chk("R1 core_rst in reset", 32'(crst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_GIE, v); chk("R1 gie", v, 0);
        rd(A_IER, v); chk("R1 ier", v, 0);
        rd(A_STS, v); chk("R1 sts", v, 0);

        // R6, R5: register widths
        wr(A_GIE, 32'hFFFF_FFFF); rd(A_GIE, v); chk("R6 gie bit31 only", v, 32'h8000_0000);
        wr(A_GIE, 32'h7FFF_FFFF); rd(A_GIE, v); chk("R6 gie cleared", v, 0);
        wr(A_IER, 32'hFFFF_FFFF); rd(A_IER, v); chk("R5 ier width", v, 32'h7F);

        // R10: holes and reset register read zero, hole writes do nothing
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R10 hole read", v, 0);
        rd(A_SRST, v); chk("R10 srst read", v, 0);
        rd(A_IER, v); chk("R10 ier untouched", v, 32'h7F);
        rd(A_STS, v); chk("R10 sts untouched", v, 0);

        // R2: each event alone sets its own bit
        for (int k = 0; k < 7; k++) begin
            pulse_evt(7'(1 << k));
            rd(A_STS, v); chk("R2 single event", v, 32'(1 << k));
            wr(A_STS, v);
            rd(A_STS, v); chk("R3 write back clears", v, 0);
        end

        // R3: partial clear
        pulse_evt(7'h7F);
        wr(A_STS, 32'h05);
        rd(A_STS, v); chk("R3 partial clear", v, 32'h7A);
        wr(A_STS, 32'hFFFF_FFFF);
        rd(A_STS, v); chk("R3 full clear", v, 0);

        // R2: a held level sets only once
        @(negedge clk); evt = 7'h01;
        @(negedge clk);
        wr(A_STS, 32'h01);
        repeat (2) @(negedge clk);
        rd(A_STS, v); chk("R2 held level no re-set", v, 0);
        evt = '0;
        @(negedge clk);

        // R4: set beats clear in the same cycle
        pulse_evt(7'h0C);
        @(negedge clk);
        wr_en = 1'b1; addr = A_STS; wdata = 32'h0C; evt = 7'h04;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        rd(A_STS, v); chk("R4 set wins", v, 32'h04);
        wr(A_STS, 32'h04);

        // R7: sweep every enable mask against a varying status pattern
        for (int m = 0; m < 128; m++) begin
            logic [6:0] p;
            p = 7'((m * 37 + 11) % 128);
            wr(A_IER, 32'(m));
            wr(A_GIE, 32'h8000_0000);
            pulse_evt(p);
            rd(A_STS, v); chk("R2 pattern latched", v, 32'(p));
            chk("R7 irq masked", 32'(irq), 32'(|(p & 7'(m))));
            wr(A_GIE, 32'h0);
            chk("R7 irq needs global enable", 32'(irq), 0);
            wr(A_GIE, 32'h8000_0000);
            rd(A_STS, v);
            wr(A_STS, v);
            rd(A_STS, v); chk("R3 sweep clear", v, 0);
            chk("R7 irq after clear", 32'(irq), 0);
        end

        // R9: wrong values to the reset register are ignored
        wr(A_IER, 32'h7F);
        pulse_evt(7'h11);
        wr(A_SRST, 32'h0000_000B);
        chk("R9 no pulse 0x0B", 32'(crst), 0);
        wr(A_SRST, 32'h0000_010A);
        chk("R9 no pulse 0x10A", 32'(crst), 0);
        repeat (2) @(negedge clk);
        chk("R9 still no pulse", 32'(crst), 0);
        rd(A_STS, v); chk("R9 sts kept", v, 32'h11);
        rd(A_IER, v); chk("R9 ier kept", v, 32'h7F);
        rd(A_GIE, v); chk("R9 gie kept", v, 32'h8000_0000);
        chk("R9 irq kept", 32'(irq), 1);

        // R8: key write clears registers and pulses core reset
        @(negedge clk);
        wr_en = 1'b1; addr = A_SRST; wdata = 32'h0000_000A; evt = 7'h02;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        for (int c = 0; c < RST_LEN; c++) begin
            chk("R8 pulse high", 32'(crst), 1);
            if (c == 0) begin
                rd(A_STS, v); chk("R8 sts cleared despite event", v, 0);
                rd(A_IER, v); chk("R8 ier cleared", v, 0);
                rd(A_GIE, v); chk("R8 gie cleared", v, 0);
                chk("R8 irq low", 32'(irq), 0);
            end
            @(negedge clk);
        end
        chk("R8 pulse ended", 32'(crst), 0);
        @(negedge clk);
        chk("R8 stays low", 32'(crst), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule